// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block sits between three external interrupt pins and an interrupt controller that understands only two kinds of request: a level that is active when high, and a rising edge. Each pin has its own 8-bit control byte. The byte sets whether the line is enabled, which of four trigger types it uses, and which of two sampling enables times its edge detection. It also holds a pending flag. Pins that are active low are inverted, so the controller sees an active-high level. Falling edges are turned into a request that rises. This lets the controller serve all four trigger types.

Every pin passes through a two-flop synchroniser. An edge is found by comparing the synchronised value against the value captured at the previous sampling enable. An edge-type line latches its pending flag until software writes one to that flag. A level-type line shows the live, polarity-corrected input instead. Software reaches the three control bytes through a plain byte-write port. A 32-bit readback word holds all three bytes packed together. There is no data stream in this block, so every pin is a plain control or status signal with no handshake.

Top module: `ext_irq_conditioner`

## Requirements
- R1: `reg_rdata` packs line 0 in bits 23:16, line 1 in bits 15:8 and line 2 in bits 7:0. Bits 31:24 and bits 3:1 of each byte read as zero.
- R2: Within a control byte, bit 0 is pending, bit 4 is fast-clock select, bit 5 is enable and bits 7:6 are the trigger code: 00 level high, 01 level low, 10 rising edge, 11 falling edge. With bit 4 at 1, edges are timed by `tick_fast`; with bit 4 at 0, by `tick_slow`.
- R3: A write with `wr_line` 0 to 2 replaces the trigger, enable and clock-select fields of that line only, from the next clock edge. A write with `wr_line` 3 changes nothing.
- R4: A change on a pin reaches the level-type pending flag and the request two clock edges after the pin settles.
- R5: For level types, pending equals enable AND the synchronised input (inverted for code 01). Writing 1 to pending has no effect.
- R6: For edge types, on a cycle where the selected tick is high, a rise (code 10) or fall (code 11) of the synchronised input against the value captured at the previous tick sets pending from the next edge, if the line is enabled.
- R7: A latched edge pending stays set until a write to that line with bit 0 at 1. A write with bit 0 at 0 leaves it set. An edge detected in the same cycle as a clear keeps it set.
- R8: While a line is disabled, its request is 0 and edges are not latched.
- R9: `irq_req[i]` is 1 exactly when line i is enabled and its pending flag reads 1. The request is therefore an active-high level or a rising step, whatever polarity is programmed.
- R10: After reset, every control field and pending flag is zero and all requests are low.
- R11: Switching a line to a level type discards any latched edge pending, so it is not seen after a later return to an edge type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fast | input | 1 | Fast sampling enable |
| tick_slow | input | 1 | Slow sampling enable |
| pin_in | input | 3 | Raw external interrupt pins, bit i is line i |
| wr_en | input | 1 | Control byte write strobe |
| wr_line | input | 2 | Line whose byte is written |
| wr_data | input | 8 | Byte written to the selected line |
| reg_rdata | output | 32 | Packed readback of all control bytes |
| irq_req | output | 3 | Conditioned requests to the interrupt controller |

## Verification
The risky overlap is a software clear of an edge pending flag that falls in the same cycle the line detects a new edge. The bench forces it on purpose. It programs line 1 for falling edges with the fast tick held high. It drops the pin, counts the two synchroniser edges, and then presents the clearing write in exactly the cycle where the edge is seen. It then expects pending and the request to stay high. A second overlap is a write that changes a line's type while an edge is pending. That case is judged by switching to a level type and back, and expecting the flag to be gone. Long random phases mix writes, pin toggles and ticks. They compare every cycle against a behavioural model.

// File: rtl/eic_pkg.sv
package eic_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_HI = 2'b00,
    TRIG_LVL_LO = 2'b01,
    TRIG_RISE   = 2'b10,
    TRIG_FALL   = 2'b11
  } trig_e;

  typedef struct packed {
    trig_e trig;
    logic  en;
    logic  fast;
  } line_ctrl_t;

  localparam int unsigned FIELD_W  = 8;
  localparam int unsigned POS_PEND = 0;
  localparam int unsigned POS_FAST = 4;
  localparam int unsigned POS_EN   = 5;
  localparam int unsigned POS_TRIG = 6;

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eic_line.sv
module eic_line
  import eic_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       tick_fast_i,
  input  logic       tick_slow_i,
  input  line_ctrl_t ctrl_i,
  input  logic       clr_i,
  output logic       pend_o,
  output logic       req_o
);
  logic pin_s;
  logic prev_q;
  logic pend_q;
  logic samp;
  logic is_edge;
  logic invert;
  logic edge_evt;
  logic level_act;

  eic_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pin_i),
    .q_o  (pin_s)
  );

  assign is_edge = ctrl_i.trig[1];
  assign invert  = ctrl_i.trig[0];
  assign samp    = ctrl_i.fast ? tick_fast_i : tick_slow_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_q <= 1'b0;
    else if (samp) prev_q <= pin_s;
  end

  always_comb begin
    edge_evt = 1'b0;
    if (samp && is_edge)
      edge_evt = invert ? (!pin_s && prev_q) : (pin_s && !prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pend_q <= 1'b0;
    else if (!is_edge)               pend_q <= 1'b0;
    else if (ctrl_i.en && edge_evt)  pend_q <= 1'b1;
    else if (clr_i)                  pend_q <= 1'b0;
  end

  assign level_act = ctrl_i.en && (pin_s ^ invert);
  assign pend_o    = is_edge ? pend_q : level_act;
  assign req_o     = ctrl_i.en && pend_o;

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.en && edge_evt) |=> pend_q);                              // R6
  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && pend_q && !clr_i) |=> pend_q);                        // R7
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && pend_q && clr_i && !edge_evt) |=> !pend_q);           // R7
  AST_DISABLED_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i.en && !pend_q) |=> !pend_q);                             // R8
  AST_LEVEL_DROPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !is_edge |=> !pend_q);                                            // R11
endmodule

// File: rtl/ext_irq_conditioner.sv
module ext_irq_conditioner
  import eic_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REG_W       = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           tick_fast,
  input  logic                           tick_slow,
  input  logic [NUM_LINES-1:0]           pin_in,
  input  logic                           wr_en,
  input  logic [$clog2(NUM_LINES)-1:0]   wr_line,
  input  logic [7:0]                     wr_data,
  output logic [REG_W-1:0]               reg_rdata,
  output logic [NUM_LINES-1:0]           irq_req
);
  localparam int unsigned SEL_W = $clog2(NUM_LINES);

  line_ctrl_t           ctrl_q [NUM_LINES];
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] hit;
  logic                 unused_wr_bits;

  assign unused_wr_bits = ^wr_data[3:1];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign hit[i] = wr_en && (wr_line == SEL_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[i] <= '{trig: TRIG_LVL_HI, en: 1'b0, fast: 1'b0};
      end else if (hit[i]) begin
        ctrl_q[i].trig <= trig_e'(wr_data[POS_TRIG +: 2]);
        ctrl_q[i].en   <= wr_data[POS_EN];
        ctrl_q[i].fast <= wr_data[POS_FAST];
      end
    end

    eic_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (pin_in[i]),
      .tick_fast_i(tick_fast),
      .tick_slow_i(tick_slow),
      .ctrl_i     (ctrl_q[i]),
      .clr_i      (hit[i] && wr_data[POS_PEND]),
      .pend_o     (pend[i]),
      .req_o      (irq_req[i])
    );

    AST_WRITE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      !hit[i] |=> $stable(ctrl_q[i]));                                // R3
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      reg_rdata[FIELD_W*(NUM_LINES-1-i) +: FIELD_W] =
        {ctrl_q[i].trig, ctrl_q[i].en, ctrl_q[i].fast, 3'b000, pend[i]};
    end
  end

  AST_REQ_ONEHOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_req) <= $countones(pend));                         // R9
endmodule

// File: tb/sim_ext_irq_conditioner.sv
module sim_ext_irq_conditioner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_fast = 1'b0, tick_slow = 1'b0;
  logic [2:0]  pin_in = 3'b000;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_line = 2'd0;
  logic [7:0]  wr_data = 8'h00;
  logic [31:0] reg_rdata;
  logic [2:0]  irq_req;

  int nvec = 0, nfail = 0;
  bit running = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_conditioner u0 (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .pin_in(pin_in), .wr_en(wr_en), .wr_line(wr_line), .wr_data(wr_data),
    .reg_rdata(reg_rdata), .irq_req(irq_req)
  );

  // behavioural reference state
  bit m_s1[3], m_s2[3], m_prev[3], m_pend[3], m_en[3], m_fast[3];
  int m_type[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0; m_pend[i] = 0;
        m_en[i] = 0; m_fast[i] = 0; m_type[i] = 0;
      end
    end else begin
      for (int i = 0; i < 3; i++) begin
        bit tick, evt, wr;
        tick = m_fast[i] ? tick_fast : tick_slow;
        evt  = 0;
        if (tick && m_type[i] == 2) evt = m_s2[i] && !m_prev[i];
        if (tick && m_type[i] == 3) evt = !m_s2[i] && m_prev[i];
        wr = wr_en && (int'(wr_line) == i);
        if (m_type[i] < 2)          m_pend[i] = 0;
        else if (m_en[i] && evt)    m_pend[i] = 1;
        else if (wr && wr_data[0])  m_pend[i] = 0;
        if (tick) m_prev[i] = m_s2[i];
        m_s2[i] = m_s1[i];
        m_s1[i] = pin_in[i];
        if (wr) begin
          m_type[i] = int'(wr_data[7:6]);
          m_en[i]   = wr_data[5];
          m_fast[i] = wr_data[4];
        end
      end
    end
  end

  function automatic bit m_pview(int i);
    if (m_type[i] < 2) return m_en[i] && (m_s2[i] ^ m_type[i][0]);
    return m_pend[i];
  endfunction

  function automatic logic [31:0] m_rdata();
    logic [31:0] r = '0;
    for (int i = 0; i < 3; i++)
      r[8*(2-i) +: 8] = {2'(m_type[i]), m_en[i], m_fast[i], 3'b000, m_pview(i)};
    return r;
  endfunction

  function automatic logic [2:0] m_irq();
    logic [2:0] q;
    for (int i = 0; i < 3; i++) q[i] = m_en[i] && m_pview(i);
    return q;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && running) begin
      chk("R1 R2 R5 R6", reg_rdata, m_rdata());
      chk("R8 R9", {29'd0, irq_req}, {29'd0, m_irq()});
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [1:0] ln, input logic [7:0] d);
    wr_en = 1'b1; wr_line = ln; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    logic [31:0] snap;
    step(3);
    rst_n = 1'b1;
    running = 1'b1;
    chk("R10 reset", {reg_rdata[31:3], irq_req}, 32'd0);

    // line 0 level low, slow clock
    wr(2'd0, 8'h60);
    chk("R9 level-low active", {31'd0, irq_req[0]}, 32'd1);
    pin_in[0] = 1'b1;
    step();
    chk("R4 one edge not yet", {31'd0, irq_req[0]}, 32'd1);
    step();
    chk("R4 two edges", {31'd0, irq_req[0]}, 32'd0);
    wr(2'd0, 8'h61);
    chk("R5 write-one on level", {31'd0, reg_rdata[16]}, 32'd0);
    snap = reg_rdata;
    wr(2'd3, 8'hFF);
    chk("R3 line 3 ignored", reg_rdata, snap);
    chk("R1 reserved bits", {24'd0, reg_rdata[31:24]}, 32'd0);

    // line 1 falling edge, fast clock
    tick_fast = 1'b1;
    pin_in[1] = 1'b1;
    wr(2'd1, 8'hF0);
    step(4);
    pin_in[1] = 1'b0;
    step(4);
    chk("R6 falling latched", {31'd0, irq_req[1]}, 32'd1);
    wr(2'd1, 8'hF0);
    chk("R7 write zero keeps", {31'd0, reg_rdata[8]}, 32'd1);
    wr(2'd1, 8'hF1);
    chk("R7 clear", {31'd0, reg_rdata[8]}, 32'd0);
    pin_in[1] = 1'b1;
    step(4);
    pin_in[1] = 1'b0;
    step(2);
    wr(2'd1, 8'hF1);           // clear in the cycle the edge is seen
    chk("R7 edge beats clear", {31'd0, reg_rdata[8]}, 32'd1);
    wr(2'd1, 8'h70);           // level low
    step();
    wr(2'd1, 8'hF0);           // back to falling edge
    chk("R11 latch dropped", {31'd0, reg_rdata[8]}, 32'd0);

    // line 2 rising, disabled then enabled on slow clock
    wr(2'd2, 8'h80);
    tick_slow = 1'b1;
    step(4);
    pin_in[2] = 1'b1;
    step(4);
    chk("R8 disabled no latch", {31'd0, reg_rdata[0]}, 32'd0);
    pin_in[2] = 1'b0;
    step(4);
    tick_slow = 1'b0;
    wr(2'd2, 8'hA0);
    pin_in[2] = 1'b1;
    step(5);
    chk("R2 waits for slow tick", {31'd0, reg_rdata[0]}, 32'd0);
    tick_slow = 1'b1;
    step();
    tick_slow = 1'b0;
    chk("R2 slow tick edge", {31'd0, irq_req[2]}, 32'd1);

    // random mix
    for (int c = 0; c < 4000; c++) begin
      tick_fast = ($urandom_range(0, 1) == 1);
      tick_slow = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 5) == 0) pin_in[$urandom_range(0, 2)] ^= 1'b1;
      wr_en   = ($urandom_range(0, 9) == 0);
      wr_line = 2'($urandom_range(0, 3));
      wr_data = 8'($urandom);
      if (wr_data[5] == 1'b0 && $urandom_range(0, 1) == 1) wr_data[5] = 1'b1;
      step();
    end
    wr_en = 1'b0;
    step(2);
    running = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule